// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD registers, advanced by a single-cycle enable that pulses at 100 Hz. The fields are hundredths of seconds, seconds, minutes, hours, day of month, month, two-digit year and a free-running day-of-week index. Each field carries into the next when it wraps. The hour field runs in either 24-hour or 12-hour form, and a mode bit stored inside the hour byte selects which one. The day of month wraps at the length of the current month, with a four-year leap rule for February.

Software sets the time through a one-field-per-cycle write port. Every field is visible at the same time on parallel read outputs. A one-cycle strobe marks each change of the seconds field, so downstream alarm comparators can run once per second.

Top module: `bcd_rtc_calendar`

## Requirements
- R1: On each `tick` with no write, `hundredths` advances in BCD through 00..99 and wraps to 00. No write select can load it.
- R2: `seconds` and `minutes` count 00..59 in BCD. Each one advances only when the field below it wraps.
- R3: The hour byte holds the mode in bit 7 (1 = 24-hour). In 24-hour mode, bits 5:0 count BCD 00..23, and 23 wraps to 00 and starts a new day.
- R4: In 12-hour mode, bits 4:0 hold BCD 01..12 and bit 5 is the PM flag. The hour runs 12,01,..,11,12, and the flag toggles on the step from 11 to 12. The step from 11 PM to 12 AM starts a new day.
- R5: `date` counts from 01 up to the month's last day and then wraps to 01. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other non-February months. A stored date at or beyond the last day also wraps.
- R6: February ends at 29 when the BCD year is divisible by 4, and at 28 otherwise.
- R7: `month` counts 01..12 and advances when the date wraps. `year` counts 00..99 and advances when the month wraps from 12 to 01.
- R8: `weekday` advances 0,1,..,6,0 at each new day, independently of the date.
- R9: After reset: hundredths 00, seconds 00, minutes 00, hour byte 0x12 (12 AM, 12-hour mode, PM clear), date 01, month 01, year 00, weekday 0, `sec_pulse` low.
- R10: A write with `wr_en` high loads the field chosen by `wr_sel` (0 seconds, 1 minutes, 2 hour byte with bit 6 forced to 0, 3 date, 4 month, 5 year, 6 weekday low bits, 7 no field). Every write clears hundredths to 00 and suppresses any increment in that cycle.
- R11: `sec_pulse` is high for exactly the one cycle in which an increment of `seconds` first appears, and it stays low in write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 100 Hz single-cycle advance enable |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | BCD value to load |
| hundredths | output | 8 | BCD hundredths of a second |
| seconds | output | 8 | BCD seconds |
| minutes | output | 8 | BCD minutes |
| hours | output | 8 | Hour byte: mode bit 7, PM bit 5, BCD hour |
| date | output | 8 | BCD day of month |
| month | output | 8 | BCD month |
| year | output | 8 | BCD year |
| weekday | output | DOW_W (3) | Day-of-week index |
| sec_pulse | output | 1 | One-cycle strobe on a seconds increment |

## Verification
A wrong carry or limit compare at any level stays invisible until that field reaches its limit. After that it shows at the ports within one clock: the next field either fails to move or moves too early, or the wrapping field lands on a value other than its minimum. The bench therefore forces the higher fields close to their limits by writes, and compares every output against a bench-side calendar model on every cycle. This way a month-length, leap or AM/PM error shows up in the first cycle after the boundary where it occurs. Random writes mixed with ticks expose write priority and the hundredths clear in the same cycle as the write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam logic [2:0] SEL_SEC  = 3'd0;
   localparam logic [2:0] SEL_MIN  = 3'd1;
   localparam logic [2:0] SEL_HOUR = 3'd2;
   localparam logic [2:0] SEL_DATE = 3'd3;
   localparam logic [2:0] SEL_MON  = 3'd4;
   localparam logic [2:0] SEL_YEAR = 3'd5;
   localparam logic [2:0] SEL_DOW  = 3'd6;

   // two-digit BCD increment (no wrap at 99, caller decides)
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // BCD year divisible by four
   function automatic logic bcd_leap(input logic [7:0] y);
      logic even_tens;
      even_tens = ~y[4];
      if (even_tens) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      else           return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
   endfunction

   // last BCD day of a BCD month
   function automatic logic [7:0] bcd_last_day(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
   parameter int         W       = 8,
   parameter logic [7:0] MIN_VAL = 8'h00,
   parameter logic [7:0] RST_VAL = 8'h00
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic [W-1:0] limit,
   output logic [W-1:0] value,
   output logic         at_limit
);
   import rtc_pkg::*;

   initial assert (W == 8) else $error("rtc_bcd_field: W must be 8 for two-digit BCD");

   logic [W-1:0] nxt;

   assign at_limit = (value >= limit);

   always_comb begin
      if (at_limit) nxt = MIN_VAL;
      else          nxt = bcd_inc(value);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    value <= RST_VAL;
      else if (load) value <= load_val;
      else if (step) value <= nxt;
   end

   // wrap lands on the field minimum
   assert_field_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && at_limit) |=> (value == MIN_VAL));

   // a valid low digit stays a decimal digit across a step
   assert_field_digit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && value[3:0] <= 4'd9) |=> (value[3:0] <= 4'd9));

endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field #(
   parameter bit RST_MIL = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] load_val,
   input  logic       step,
   output logic [7:0] value,
   output logic       day_last
);
   import rtc_pkg::*;

   localparam logic [7:0] RST_HOUR = RST_MIL ? 8'h80 : 8'h12;

   logic       mil;
   logic       pm;
   logic [4:0] h12;
   logic [5:0] h24;
   logic [7:0] inc24;
   logic [7:0] inc12;
   logic [7:0] nxt;

   assign mil   = value[7];
   assign pm    = value[5];
   assign h12   = value[4:0];
   assign h24   = value[5:0];
   assign inc24 = bcd_inc({2'b00, h24});
   assign inc12 = bcd_inc({3'b000, h12});

   generate
      if (RST_MIL) begin : g_day_end_24_first
         assign day_last = mil ? (h24 >= 6'h23) : (pm && h12 == 5'h11);
      end else begin : g_day_end_12_first
         assign day_last = !mil ? (pm && h12 == 5'h11) : (h24 >= 6'h23);
      end
   endgenerate

   always_comb begin
      if (mil) begin
         if (h24 >= 6'h23) nxt = 8'h80;
         else              nxt = {2'b10, inc24[5:0]};
      end else begin
         if (h12 == 5'h11)       nxt = {2'b00, ~pm, 5'h12};
         else if (h12 >= 5'h12)  nxt = {2'b00, pm, 5'h01};
         else                    nxt = {2'b00, pm, inc12[4:0]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    value <= RST_HOUR;
      else if (load) value <= {load_val[7], 1'b0, load_val[5:0]};
      else if (step) value <= nxt;
   end

   assert_h24_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && mil && h24 == 6'h23) |=> (value == 8'h80));

   assert_h12_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !mil) |=> (value[4:0] != 5'h00));

   assert_pm_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !mil && h12 == 5'h11) |=> (value[5] != $past(value[5])));

   assert_mode_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load) |=> (value[7] == $past(value[7])));

endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar #(
   parameter int DAYS_PER_WEEK = 7,
   parameter int DOW_W         = $clog2(DAYS_PER_WEEK),
   parameter bit RESET_MIL     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [7:0]       wr_data,
   output logic [7:0]       hundredths,
   output logic [7:0]       seconds,
   output logic [7:0]       minutes,
   output logic [7:0]       hours,
   output logic [7:0]       date,
   output logic [7:0]       month,
   output logic [7:0]       year,
   output logic [DOW_W-1:0] weekday,
   output logic             sec_pulse
);
   import rtc_pkg::*;

   initial assert (DAYS_PER_WEEK >= 2 && DAYS_PER_WEEK <= (1 << DOW_W))
      else $error("bcd_rtc_calendar: DAYS_PER_WEEK does not fit DOW_W");

   localparam int N_SUB = 3;   // hundredths, seconds, minutes
   localparam logic [DOW_W-1:0] DOW_LAST = DOW_W'(DAYS_PER_WEEK - 1);

   logic [7:0] sub_val  [N_SUB];
   logic       sub_step [N_SUB];
   logic       sub_top  [N_SUB];

   logic hour_step, day_last, day_step;
   logic date_top, month_step, month_top, year_step, year_top;
   logic [7:0] date_limit;

   // ---------------- time-of-day chain below the hour ----------------
   generate
      for (genvar g = 0; g < N_SUB; g++) begin : g_sub
         localparam logic [7:0] LIM = (g == 0) ? 8'h99 : 8'h59;
         logic       ld;
         logic [7:0] lv;
         if (g == 0) begin : g_base
            assign sub_step[g] = tick && !wr_en;
            assign ld          = wr_en;
            assign lv          = 8'h00;
         end else begin : g_carry
            assign sub_step[g] = sub_step[g-1] && sub_top[g-1];
            assign ld          = wr_en && (wr_sel == 3'(g - 1));
            assign lv          = wr_data;
         end
         rtc_bcd_field #(.W(8), .MIN_VAL(8'h00), .RST_VAL(8'h00)) u_fld (
            .clk(clk), .rst_n(rst_n), .load(ld), .load_val(lv),
            .step(sub_step[g]), .limit(LIM), .value(sub_val[g]), .at_limit(sub_top[g]));
      end
   endgenerate

   assign hundredths = sub_val[0];
   assign seconds    = sub_val[1];
   assign minutes    = sub_val[2];

   // ---------------- hour ----------------
   assign hour_step = sub_step[N_SUB-1] && sub_top[N_SUB-1];

   rtc_hour_field #(.RST_MIL(RESET_MIL)) u_hour (
      .clk(clk), .rst_n(rst_n),
      .load(wr_en && wr_sel == SEL_HOUR), .load_val(wr_data),
      .step(hour_step), .value(hours), .day_last(day_last));

   assign day_step = hour_step && day_last;

   // ---------------- calendar ----------------
   assign date_limit = bcd_last_day(month, year);

   rtc_bcd_field #(.W(8), .MIN_VAL(8'h01), .RST_VAL(8'h01)) u_date (
      .clk(clk), .rst_n(rst_n), .load(wr_en && wr_sel == SEL_DATE), .load_val(wr_data),
      .step(day_step), .limit(date_limit), .value(date), .at_limit(date_top));

   assign month_step = day_step && date_top;

   rtc_bcd_field #(.W(8), .MIN_VAL(8'h01), .RST_VAL(8'h01)) u_month (
      .clk(clk), .rst_n(rst_n), .load(wr_en && wr_sel == SEL_MON), .load_val(wr_data),
      .step(month_step), .limit(8'h12), .value(month), .at_limit(month_top));

   assign year_step = month_step && month_top;

   rtc_bcd_field #(.W(8), .MIN_VAL(8'h00), .RST_VAL(8'h00)) u_year (
      .clk(clk), .rst_n(rst_n), .load(wr_en && wr_sel == SEL_YEAR), .load_val(wr_data),
      .step(year_step), .limit(8'h99), .value(year), .at_limit(year_top));

   // ---------------- day of week and second strobe ----------------
   always_ff @(posedge clk) begin
      if (!rst_n)                          weekday <= '0;
      else if (wr_en && wr_sel == SEL_DOW) weekday <= wr_data[DOW_W-1:0];
      else if (day_step)                   weekday <= (weekday >= DOW_LAST) ? '0 : weekday + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sec_pulse <= 1'b0;
      else        sec_pulse <= sub_step[1];
   end

   assert_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (hundredths == 8'h00 && !sec_pulse));

   assert_pulse_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |-> (hundredths == 8'h00 && $past(tick) && !$past(wr_en)));

   assert_dow_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (day_step && !wr_en && weekday == DOW_LAST) |=> (weekday == '0));

   assert_leap_day_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (day_step && !wr_en && month == 8'h02 && date == 8'h28 && bcd_leap(year))
      |=> (date == 8'h29));

   assert_year_roll_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (year_step && !wr_en && year == 8'h99) |=> (year == 8'h00 && month == 8'h01));

endmodule

// File: tb/sim_bcd_rtc_calendar.sv
module sim_bcd_rtc_calendar;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] hundredths, seconds, minutes, hours, date, month, year;
   logic [2:0] weekday;
   logic       sec_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench-side calendar model (binary)
   int m_hs, m_s, m_m, m_hr, m_date, m_mon, m_year, m_dow;
   bit m_mil, m_pm, m_pulse;

   bcd_rtc_calendar u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .hundredths(hundredths), .seconds(seconds), .minutes(minutes),
      .hours(hours), .date(date), .month(month), .year(year), .weekday(weekday),
      .sec_pulse(sec_pulse));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int from_bcd(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic int mlen(input int mon, input int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] exp_hours();
      logic [7:0] b;
      b = to_bcd(m_hr);
      if (m_mil) return {2'b10, b[5:0]};
      return {2'b00, m_pm, b[4:0]};
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(input bit after_reset);
      chk(after_reset ? "R9 hundredths" : "R1 hundredths", hundredths, to_bcd(m_hs));
      chk(after_reset ? "R9 seconds"    : "R2 seconds",    seconds,    to_bcd(m_s));
      chk(after_reset ? "R9 minutes"    : "R2 minutes",    minutes,    to_bcd(m_m));
      chk(after_reset ? "R9 hours" : (m_mil ? "R3 hours" : "R4 hours"), hours, exp_hours());
      chk(after_reset ? "R9 date"       : "R5 date",       date,       to_bcd(m_date));
      chk(after_reset ? "R9 month"      : "R7 month",      month,      to_bcd(m_mon));
      chk(after_reset ? "R9 year"       : "R7 year",       year,       to_bcd(m_year));
      chk(after_reset ? "R9 weekday"    : "R8 weekday",    {5'd0, weekday}, 8'(m_dow));
      chk(after_reset ? "R9 sec_pulse"  : "R11 sec_pulse", {7'd0, sec_pulse}, {7'd0, m_pulse});
   endtask

   task automatic model_new_day();
      m_dow = (m_dow >= 6) ? 0 : m_dow + 1;
      if (m_date >= mlen(m_mon, m_year)) begin
         m_date = 1;
         if (m_mon >= 12) begin
            m_mon = 1;
            m_year = (m_year >= 99) ? 0 : m_year + 1;
         end else m_mon++;
      end else m_date++;
   endtask

   task automatic model_hour();
      bit new_day = 0;
      if (m_mil) begin
         if (m_hr >= 23) begin m_hr = 0; new_day = 1; end
         else m_hr++;
      end else begin
         if (m_hr == 11) begin
            if (m_pm) new_day = 1;
            m_pm = !m_pm;
            m_hr = 12;
         end else if (m_hr >= 12) m_hr = 1;
         else m_hr++;
      end
      if (new_day) model_new_day();
   endtask

   task automatic model_update(input bit t, input bit w, input logic [2:0] s,
                               input logic [7:0] d);
      m_pulse = 0;
      if (w) begin
         m_hs = 0;
         case (s)
            3'd0: m_s = from_bcd(d);
            3'd1: m_m = from_bcd(d);
            3'd2: begin
               m_mil = d[7];
               m_pm  = d[5];
               m_hr  = d[7] ? from_bcd({2'b00, d[5:0]}) : from_bcd({3'b000, d[4:0]});
            end
            3'd3: m_date = from_bcd(d);
            3'd4: m_mon  = from_bcd(d);
            3'd5: m_year = from_bcd(d);
            3'd6: m_dow  = int'(d[2:0]);
            default: ;
         endcase
      end else if (t) begin
         m_hs++;
         if (m_hs == 100) begin
            m_hs = 0;
            m_pulse = 1;
            m_s++;
            if (m_s == 60) begin
               m_s = 0;
               m_m++;
               if (m_m == 60) begin
                  m_m = 0;
                  model_hour();
               end
            end
         end
      end
   endtask

   // called at a falling edge; leaves the bench at the next falling edge
   task automatic step(input bit t, input bit w, input logic [2:0] s, input logic [7:0] d);
      tick = t; wr_en = w; wr_sel = s; wr_data = d;
      model_update(t, w, s, d);
      @(posedge clk);
      @(negedge clk);
      check_all(0);
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      step(0, 1, s, d);
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) step(1, 0, 3'd0, 8'h00);
   endtask

   task automatic set_all(input logic [7:0] hr, input logic [7:0] dt,
                          input logic [7:0] mo, input logic [7:0] yr);
      wr(3'd2, hr); wr(3'd3, dt); wr(3'd4, mo); wr(3'd5, yr);
      wr(3'd1, 8'h59); wr(3'd0, 8'h59);
   endtask

   function automatic logic [7:0] rand_data(input logic [2:0] s);
      case (s)
         3'd0, 3'd1: return ($urandom % 2) ? 8'h59 : to_bcd($urandom % 60);
         3'd2:
            if ($urandom % 2) return {2'b10, 6'(to_bcd(($urandom % 2) ? 23 : $urandom % 24))};
            else return {2'b00, 1'($urandom % 2),
                         5'(to_bcd(($urandom % 2) ? 11 : 1 + $urandom % 12))};
         3'd3: return to_bcd(($urandom % 2) ? 28 + $urandom % 4 : 1 + $urandom % 31);
         3'd4: return to_bcd(1 + $urandom % 12);
         3'd5: return to_bcd($urandom % 100);
         3'd6: return 8'($urandom % 7);
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      m_hs = 0; m_s = 0; m_m = 0; m_mil = 0; m_hr = 12; m_pm = 0;
      m_date = 1; m_mon = 1; m_year = 0; m_dow = 0; m_pulse = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_all(1);                       // R9 reset state

      run_ticks(250);                     // R1 R11 plain counting

      // R4: 11 AM -> 12 PM
      set_all(8'h11, 8'h10, 8'h03, 8'h21);
      run_ticks(100);
      chk("R4 noon", hours, 8'h32);
      chk("R11 pulse at carry", {7'd0, sec_pulse}, 8'h01);

      // R4: 11 PM -> 12 AM, new day
      set_all(8'h31, 8'h15, 8'h03, 8'h21);
      run_ticks(100);
      chk("R4 midnight", hours, 8'h12);
      chk("R4 date advance", date, 8'h16);

      // R3: 23 -> 00 in 24-hour mode, R5 April 30 -> May 1
      set_all(8'hA3, 8'h30, 8'h04, 8'h21);
      run_ticks(100);
      chk("R3 wrap", hours, 8'h80);
      chk("R5 30-day month", date, 8'h01);
      chk("R5 month after April", month, 8'h05);

      // R6 leap rules
      set_all(8'hA3, 8'h28, 8'h02, 8'h23);
      run_ticks(100);
      chk("R6 common year", date, 8'h01);
      set_all(8'hA3, 8'h28, 8'h02, 8'h24);
      run_ticks(100);
      chk("R6 leap year day 29", date, 8'h29);
      set_all(8'hA3, 8'h29, 8'h02, 8'h24);
      run_ticks(100);
      chk("R6 leap year end", month, 8'h03);

      // R7 year wrap, R8 weekday wrap
      wr(3'd6, 8'h06);
      set_all(8'hA3, 8'h31, 8'h12, 8'h99);
      run_ticks(100);
      chk("R7 year wrap", year, 8'h00);
      chk("R7 month wrap", month, 8'h01);
      chk("R8 weekday wrap", {5'd0, weekday}, 8'h00);

      // R10 write priority over tick, and the no-field select
      run_ticks(37);
      step(1, 1, 3'd0, 8'h30);
      chk("R10 write beats tick", hundredths, 8'h00);
      chk("R10 seconds loaded", seconds, 8'h30);
      run_ticks(12);
      step(1, 1, 3'd7, 8'h55);
      chk("R10 no-field write clears", hundredths, 8'h00);
      chk("R10 no-field write keeps seconds", seconds, 8'h30);

      // random mix
      for (int i = 0; i < 20000; i++) begin
         logic [2:0] s;
         s = 3'($urandom % 8);
         if ($urandom % 24 == 0) step(1'($urandom % 2), 1, s, rand_data(s));
         else step(($urandom % 4) != 0, 0, 3'd0, 8'h00);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule